// File: doc/BRIEF.md
# PHY control-register port master

This block performs one register read or one register write at a time on a PHY's serial control-register port. The port has no free-running clock. The master produces every port-clock pulse itself, and each pulse has a high phase and a low phase of a fixed number of system clocks. Before each access the master sends a long run of idle pulses. It then selects the port and presents the address, plus the data for a write. It strobes the command for exactly one pulse. It then polls the acknowledge line, and every failed poll costs one further pulse.

On the host side a request is taken only while the block reports ready. The master drives the port through the whole sequence. It then returns a single-cycle completion pulse. That pulse carries either the read data or a timeout flag, which is set when the acknowledge never arrived within the retry budget. All outputs sit at zero between accesses.

Top module: `phy_cr_master`

## Requirements
- R1: After a request is accepted, the port clock gives exactly PRE_PULSES (default 100) pulses while select, write-enable and read-enable stay low and the address and write-data outputs read zero. The first pulse starts in the cycle after acceptance.
- R2: Every port-clock pulse is PHASE_CYC (default 2) cycles high followed by PHASE_CYC cycles low. The clock is low at all other times, and pulses in a run follow each other without gaps.
- R3: In the cycle after the last preamble pulse, select rises and the latched address appears. For a write (req_write = 1) the write data appears as well; for a read the write-data output stays zero. No enable is raised in this cycle.
- R4: In the following cycle exactly one enable rises: write-enable for a write, read-enable for a read. It is held through exactly one port-clock pulse, which starts the next cycle, and it falls in the cycle after that pulse's last low cycle.
- R5: Acknowledge is sampled in the first cycle after the command pulse. When it is low, one port-clock pulse follows at once and acknowledge is sampled again in the cycle after that pulse.
- R6: After RETRY_MAX (default 1000) samples in a row with acknowledge low, each followed by its extra pulse, the access ends with rsp_done and rsp_timeout both high and rsp_rdata zero.
- R7: For a read, rsp_rdata carries the phy_rdata value from the cycle in which acknowledge was sampled high. For a write, rsp_rdata is zero.
- R8: rsp_done is high for exactly one cycle, the cycle after a high acknowledge is sampled (or after the final timeout pulse). In that cycle select and both enables are already low.
- R9: req_ready is high exactly when the block is idle, including the completion cycle. A request presented while req_ready is low has no effect on any output.
- R10: During and after reset every output except req_ready is zero, and req_ready is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Data for a write access |
| req_ready | output | 1 | Block idle and able to take a request |
| rsp_done | output | 1 | Single-cycle completion pulse |
| rsp_timeout | output | 1 | Access ended without acknowledge (with rsp_done) |
| rsp_rdata | output | 16 | Read result (valid with rsp_done) |
| phy_clk | output | 1 | Logic-generated port clock |
| phy_sel | output | 1 | Port select |
| phy_addr | output | 16 | Port address bus |
| phy_wdata | output | 16 | Port write-data bus |
| phy_we | output | 1 | Write command enable |
| phy_re | output | 1 | Read command enable |
| phy_ack | input | 1 | Acknowledge from the PHY |
| phy_rdata | input | 16 | Read data from the PHY |

## Verification
The assertions assume that phy_ack and phy_rdata are stable in the cycles where the master samples them, that is, the polling cycles. They also assume that the pulse generator is restarted only when it is idle or on the last cycle of a pulse. The bench changes acknowledge and read data only on the falling system-clock edge. It raises acknowledge after a chosen number of port-clock rising edges counted while select is high. This places every change well away from a sampling edge. Requests are presented for one cycle, and one extra request is deliberately issued while an access is in flight.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE,
        GEN_HI,
        GEN_LO
    } gen_ph_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_SETUP,
        S_ARM,
        S_CMD,
        S_POLL,
        S_WAIT
    } seq_st_e;

endpackage

// File: rtl/pcr_tally.sv
// Event counter that flags the last count before LIMIT.
module pcr_tally #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (step_i)
            cnt_d = cnt_q + CW'(1);
        last_o = (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pcr_pulse_gen.sv
// Produces one port-clock pulse (high phase, then low phase) per start.
module pcr_pulse_gen
    import pcr_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pclk_o,
    output logic last_o
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] TOP = CW'(PHASE_CYC - 1);

    typedef struct packed {
        gen_ph_e       ph;
        logic [CW-1:0] cnt;
    } gen_t;

    gen_t q, d;
    logic at_top;

    always_comb begin
        d      = q;
        at_top = (q.cnt == TOP);
        last_o = (q.ph == GEN_LO) && at_top;
        case (q.ph)
            GEN_IDLE: begin
                if (start_i) begin
                    d.ph  = GEN_HI;
                    d.cnt = '0;
                end
            end
            GEN_HI: begin
                if (at_top) begin
                    d.ph  = GEN_LO;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            GEN_LO: begin
                if (at_top) begin
                    d.ph  = start_i ? GEN_HI : GEN_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d = '{ph: GEN_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '{ph: GEN_IDLE, cnt: '0};
        else
            q <= d;
    end

    assign pclk_o = (q.ph == GEN_HI);

    // R2
    start_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (q.ph == GEN_IDLE) || last_o);

    // R2
    low_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pclk_o) |-> (q.ph == GEN_LO) && (q.cnt == '0));
endmodule

// File: rtl/pcr_seq.sv
// Transaction sequencer: preamble, setup, command, acknowledge polling.
module pcr_seq
    import pcr_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int PRE_PULSES = 100,
    parameter int RETRY_MAX  = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          req_ready_o,
    output logic          done_o,
    output logic          tmo_o,
    output logic [DW-1:0] rdata_o,
    output logic          sel_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          we_o,
    output logic          re_o,
    input  logic          ack_i,
    input  logic [DW-1:0] phy_rdata_i,
    input  logic          gen_last_i,
    output logic          pulse_start_o
);
    typedef struct packed {
        seq_st_e       st;
        logic          dir;
        logic          sel;
        logic          we;
        logic          re;
        logic          give_up;
        logic          done;
        logic          tmo;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: S_IDLE, default: '0};

    seq_t q, d;
    logic pre_clr, pre_step, pre_last;
    logic rt_clr, rt_step, rt_last;

    pcr_tally #(.LIMIT(PRE_PULSES)) u_pre_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (pre_clr),
        .step_i(pre_step),
        .last_o(pre_last)
    );

    pcr_tally #(.LIMIT(RETRY_MAX)) u_retry_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (rt_clr),
        .step_i(rt_step),
        .last_o(rt_last)
    );

    always_comb begin
        d             = q;
        d.done        = 1'b0;
        d.tmo         = 1'b0;
        d.rdata       = '0;
        pulse_start_o = 1'b0;
        pre_clr       = 1'b0;
        pre_step      = 1'b0;
        rt_clr        = 1'b0;
        rt_step       = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid_i) begin
                    d.st          = S_PRE;
                    d.dir         = req_write_i;
                    d.addr        = req_addr_i;
                    d.wdata       = req_wdata_i;
                    pre_clr       = 1'b1;
                    pulse_start_o = 1'b1;
                end
            end
            S_PRE: begin
                if (gen_last_i) begin
                    if (pre_last) begin
                        d.st  = S_SETUP;
                        d.sel = 1'b1;
                    end else begin
                        pre_step      = 1'b1;
                        pulse_start_o = 1'b1;
                    end
                end
            end
            S_SETUP: begin
                d.st   = S_ARM;
                d.we   = q.dir;
                d.re   = !q.dir;
                rt_clr = 1'b1;
            end
            S_ARM: begin
                d.st          = S_CMD;
                pulse_start_o = 1'b1;
            end
            S_CMD: begin
                if (gen_last_i) begin
                    d.st = S_POLL;
                    d.we = 1'b0;
                    d.re = 1'b0;
                end
            end
            S_POLL: begin
                if (ack_i) begin
                    d.st    = S_IDLE;
                    d.sel   = 1'b0;
                    d.done  = 1'b1;
                    d.rdata = q.dir ? '0 : phy_rdata_i;
                end else begin
                    d.st          = S_WAIT;
                    d.give_up     = rt_last;
                    rt_step       = 1'b1;
                    pulse_start_o = 1'b1;
                end
            end
            S_WAIT: begin
                if (gen_last_i) begin
                    if (q.give_up) begin
                        d.st      = S_IDLE;
                        d.sel     = 1'b0;
                        d.done    = 1'b1;
                        d.tmo     = 1'b1;
                        d.give_up = 1'b0;
                    end else begin
                        d.st = S_POLL;
                    end
                end
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= SEQ_RST;
        else
            q <= d;
    end

    assign req_ready_o = (q.st == S_IDLE);
    assign done_o      = q.done;
    assign tmo_o       = q.tmo;
    assign rdata_o     = q.rdata;
    assign sel_o       = q.sel;
    assign addr_o      = q.sel ? q.addr : '0;
    assign wdata_o     = (q.sel && q.dir) ? q.wdata : '0;
    assign we_o        = q.we;
    assign re_o        = q.re;

    // R4
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.we && q.re));

    // R3
    cmd_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.we || q.re) |-> q.sel);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R6
    tmo_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tmo |-> (q.done && (q.rdata == '0)));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel && $past(q.sel)) |-> $stable(q.addr));
endmodule

// File: rtl/phy_cr_master.sv
// Top: PHY control-register port master.
module phy_cr_master #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int PRE_PULSES = 100,
    parameter int RETRY_MAX  = 1000,
    parameter int PHASE_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_done,
    output logic          rsp_timeout,
    output logic [DW-1:0] rsp_rdata,
    output logic          phy_clk,
    output logic          phy_sel,
    output logic [AW-1:0] phy_addr,
    output logic [DW-1:0] phy_wdata,
    output logic          phy_we,
    output logic          phy_re,
    input  logic          phy_ack,
    input  logic [DW-1:0] phy_rdata
);
    logic pulse_start;
    logic pulse_last;

    pcr_pulse_gen #(.PHASE_CYC(PHASE_CYC)) u_pulse_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(pulse_start),
        .pclk_o (phy_clk),
        .last_o (pulse_last)
    );

    pcr_seq #(
        .AW        (AW),
        .DW        (DW),
        .PRE_PULSES(PRE_PULSES),
        .RETRY_MAX (RETRY_MAX)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_wdata_i  (req_wdata),
        .req_ready_o  (req_ready),
        .done_o       (rsp_done),
        .tmo_o        (rsp_timeout),
        .rdata_o      (rsp_rdata),
        .sel_o        (phy_sel),
        .addr_o       (phy_addr),
        .wdata_o      (phy_wdata),
        .we_o         (phy_we),
        .re_o         (phy_re),
        .ack_i        (phy_ack),
        .phy_rdata_i  (phy_rdata),
        .gen_last_i   (pulse_last),
        .pulse_start_o(pulse_start)
    );

    // R4
    cmd_drop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_we || phy_re) |-> !phy_clk);

    // R1
    sel_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_sel) |-> (!phy_clk && !phy_we && !phy_re));

    // R8
    done_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!phy_sel && !phy_we && !phy_re && req_ready));
endmodule

// File: tb/phy_cr_master_bench.sv
module phy_cr_master_bench;
    localparam int P     = 2;
    localparam int PRE   = 100;
    localparam int RETRY = 1000;

    typedef struct packed {
        logic        pc, sl, we, re, dn, to, rdy;
        logic [15:0] ad, wd, rd;
        logic [3:0]  tg;
    } exp_t;

    localparam exp_t IDLE_E = '{rdy: 1'b1, tg: 4'd10, default: '0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_done, rsp_timeout;
    logic [15:0] rsp_rdata;
    logic        phy_clk, phy_sel, phy_we, phy_re;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;

    int checks = 0, errors = 0, cyc = 0;
    int ack_after = 0;
    bit ack_never = 0;
    int rises = 0;
    logic prev_pclk = 1'b0;

    exp_t        expq[$];
    exp_t        cur = IDLE_E;
    logic [15:0] m_addr, m_wdata;
    logic        m_wr;

    always #5 clk = ~clk;

    phy_cr_master u_phy_cr_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
        .phy_clk(phy_clk), .phy_sel(phy_sel), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_we(phy_we), .phy_re(phy_re),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    function automatic string tname(logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic add(int n, logic pc, logic sl, logic w, logic r,
                       logic dn, logic to, logic [15:0] rd, logic rdy, logic [3:0] tg);
        exp_t e;
        e.pc = pc; e.sl = sl; e.we = w; e.re = r; e.dn = dn; e.to = to;
        e.rdy = rdy; e.rd = rd; e.tg = tg;
        e.ad = sl ? m_addr : 16'h0;
        e.wd = (sl && m_wr) ? m_wdata : 16'h0;
        for (int i = 0; i < n; i++) expq.push_back(e);
    endtask

    // Behavioural expectation of one whole access, built at acceptance.
    task automatic build();
        bit ok = 0;
        m_addr = req_addr; m_wdata = req_wdata; m_wr = req_write;
        for (int i = 0; i < PRE; i++) begin
            add(P, 1, 0, 0, 0, 0, 0, 0, 0, 4'd1);
            add(P, 0, 0, 0, 0, 0, 0, 0, 0, 4'd1);
        end
        add(1, 0, 1, 0, 0, 0, 0, 0, 0, 4'd3);
        add(1, 0, 1, m_wr, !m_wr, 0, 0, 0, 0, 4'd4);
        add(P, 1, 1, m_wr, !m_wr, 0, 0, 0, 0, 4'd4);
        add(P, 0, 1, m_wr, !m_wr, 0, 0, 0, 0, 4'd4);
        for (int j = 0; j < RETRY; j++) begin
            add(1, 0, 1, 0, 0, 0, 0, 0, 0, 4'd5);
            if (!ack_never && j >= ack_after) begin ok = 1; break; end
            add(P, 1, 1, 0, 0, 0, 0, 0, 0, 4'd5);
            add(P, 0, 1, 0, 0, 0, 0, 0, 0, 4'd5);
        end
        add(1, 0, 0, 0, 0, 1, !ok, (ok && !m_wr) ? phy_rdata : 16'h0, 1, 4'd10);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            expq.delete();
            cur = IDLE_E;
        end else begin
            if (req_valid && cur.rdy) build();
            if (expq.size() > 0) cur = expq.pop_front();
            else cur = IDLE_E;
        end
    end

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Compare on every cycle, away from the active edge; drive ack model.
    always @(negedge clk) begin
        chk({"R2 ", tname(cur.tg)}, "phy_clk", 16'(phy_clk), 16'(cur.pc));
        chk("R3", "phy_sel", 16'(phy_sel), 16'(cur.sl));
        chk("R3", "phy_addr", phy_addr, cur.ad);
        chk("R3", "phy_wdata", phy_wdata, cur.wd);
        chk("R4", "phy_we", 16'(phy_we), 16'(cur.we));
        chk("R4", "phy_re", 16'(phy_re), 16'(cur.re));
        chk("R8", "rsp_done", 16'(rsp_done), 16'(cur.dn));
        chk("R6", "rsp_timeout", 16'(rsp_timeout), 16'(cur.to));
        chk("R7", "rsp_rdata", rsp_rdata, cur.rd);
        chk("R9", "req_ready", 16'(req_ready), 16'(cur.rdy));
        if (!phy_sel) rises = 0;
        else if (phy_clk && !prev_pclk) rises++;
        prev_pclk = phy_clk;
        phy_ack = phy_sel && !ack_never && (rises >= ack_after + 1);
    end

    task automatic request(logic wr, logic [15:0] a, logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_access();
        while (expq.size() > 0 || !cur.rdy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog R5 actual=%0d expected<150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R10: outputs idle during reset
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 R7: write, immediate ack, rdata must stay zero
        ack_after = 0; ack_never = 0; phy_rdata = 16'h7777;
        request(1'b1, 16'h1234, 16'hA5C3);
        finish_access();

        // R5 R7: read, ack after three extra pulses
        ack_after = 3; phy_rdata = 16'hBEEF;
        request(1'b0, 16'h00FF, 16'h9999);
        finish_access();

        // R6: read with no acknowledge at all -> timeout, no data
        ack_never = 1; phy_rdata = 16'h5555;
        request(1'b0, 16'h0F0F, 16'h0000);
        finish_access();

        // R5 R6: write acknowledged on the very last permitted sample
        ack_never = 0; ack_after = RETRY - 1;
        request(1'b1, 16'h8001, 16'hFFFF);
        finish_access();

        // R9: second request while busy must be ignored
        ack_after = 1; phy_rdata = 16'h0123;
        request(1'b0, 16'h4242, 16'h0000);
        repeat (50) @(negedge clk);
        request(1'b1, 16'hDEAD, 16'hC0DE);
        finish_access();

        // R7 R8: read of all-ones address and data
        ack_after = 0; phy_rdata = 16'hFFFF;
        request(1'b0, 16'hFFFF, 16'h0000);
        finish_access();

        // R10: reset mid-access returns everything to idle
        request(1'b1, 16'h3333, 16'h4444);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule